// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block walks an SD card through power-up and identification in SPI mode. A `start` pulse begins a fixed sequence: it wakes the card with dummy clocking, resets it, probes its voltage range, and then runs one of two polling loops. Which loop runs depends on whether the card accepted the voltage probe. It then fixes the transfer block length. When the sequence ends, the block pulses `done` and presents the result: a card-type code, the unit by which a block number must be multiplied to form a card address, and a select for the fast serial clock.

The block does not shift bits itself. Every byte-level operation goes to a command framer through a request/response pair. A request is either a wake request (clock a given number of 0xFF bytes with chip-select high) or a command (6-bit index and 32-bit argument). `req_valid` rises with a stable payload and stays high until a cycle in which `req_ready` is also high. That cycle is the acceptance, and the framer may hold `req_ready` low for as long as it likes. Only one request is outstanding at a time. The framer answers each accepted request with exactly one `rsp_valid` pulse carrying the first reply byte, at least one cycle after acceptance. The block has no ready on the response side and always takes the byte. A framer timeout is reported as a reply with bit 7 set.

Top module: `sdcard_bringup`

## Requirements
- R1: A `start` pulse while idle raises `busy` and issues a wake request (`req_dummy`=1, `req_arg`=WAKE_BYTES, default 16) as the first request. A `start` pulse while `busy` is high has no effect on the request stream or the result.
- R2: After the wake reply the block sends index 0 with argument 0. Any reply other than exactly 0x01 ends the run as a failure.
- R3: It then sends index 8 with argument 0x000001AA. A reply of 0x01 selects the version-2 path, 0x05 selects the version-1 path, and any other reply ends the run as a failure.
- R4: On the version-1 path each attempt is index 55 (reply ignored) followed by index 41 with argument 0. A reply of 0x00 to index 41 identifies the card as `card_type`=1 with `addr_unit`=512.
- R5: On the version-2 path each attempt is index 58, index 55 and then index 41 with argument 0x40000000. After a reply of 0x00 to index 41, one more index 58 is sent, and the card is identified as `card_type`=2 with `addr_unit`=1.
- R6: Either loop makes at most RETRY_LIMIT attempts. If the last permitted attempt still gets a non-zero reply from index 41, the run ends as a failure and no further request is made.
- R7: Before every version-2 attempt, `req_valid` for its index 58 rises exactly `gap_cycles`+2 cycles after the cycle in which the reply that led to it was presented.
- R8: After identification the block sends index 16 with argument 512. A non-zero reply ends the run as a failure.
- R9: `done` is a one-cycle pulse in the cycle after the final reply, and `busy` falls in that same cycle. On success `fast_clk_sel`=1 and `status`=0x00. On failure `card_type`=0, `addr_unit`=0, `fast_clk_sel`=0 and `status`=0x01. While a run is in progress, and after reset, `status`=0x01 and `fast_clk_sel`=0.
- R10: A request's payload holds steady while `req_valid` is high and `req_ready` is low. Except for the waits of R7, each follow-on request is raised in the cycle after the reply that caused it. No request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| gap_cycles | input | GAP_W | Idle cycles inserted before each version-2 attempt |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| card_type | output | 2 | 0 fail, 1 version 1, 2 version 2 |
| addr_unit | output | UNIT_W | Block-to-address multiplier (512 or 1, 0 on fail) |
| fast_clk_sel | output | 1 | Select the fast serial clock |
| status | output | 8 | 0x01 until a successful run, then 0x00 |
| req_valid | output | 1 | Request to the framer is valid |
| req_ready | input | 1 | Framer accepts the request |
| req_dummy | output | 1 | 1: wake clocking request, 0: command |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument, or wake byte count |
| rsp_valid | input | 1 | Reply byte present (one cycle per request) |
| rsp_byte | input | 8 | First reply byte from the card |

## Verification
The bench goes after each branch point with a reply that sits just beside the accepted value: a reset reply of 0x00, a voltage-probe reply of 0x09, and a block-length reply of 0x04. A sequencer that tests single bits instead of whole bytes would carry on into the wrong path or report success. It runs both loops with the card becoming ready on the very last permitted attempt and with one attempt too many. An off-by-one in the retry limit then shows up either as a premature failure or as an extra command the framer never expected. It stretches acceptance with back-pressure and varies the version-2 wait, so a payload that changes before acceptance or a wait counted from the wrong edge is seen on the exact cycle. A mid-run start pulse is also applied, which a design that restarts would reveal as a second wake request.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [1:0] {
    CARD_FAIL = 2'd0,
    CARD_V1   = 2'd1,
    CARD_V2   = 2'd2
  } card_e;

  typedef enum logic [1:0] {
    P_IDLE,
    P_GAP,
    P_BUSY
  } phase_e;

  // Which request of the sequence is in flight (or about to be issued).
  typedef enum logic [3:0] {
    ST_WAKE,
    ST_RST,
    ST_VCHK,
    ST_APP1,
    ST_OP1,
    ST_OCR,
    ST_APP2,
    ST_OP2,
    ST_OCR_FIN,
    ST_BLEN
  } step_e;

  typedef struct packed {
    logic        dummy;
    logic [5:0]  idx;
    logic [31:0] arg;
  } req_t;

  localparam logic [7:0]  REPLY_IDLE     = 8'h01;
  localparam logic [7:0]  REPLY_IDLE_ILL = 8'h05;
  localparam logic [7:0]  REPLY_READY    = 8'h00;
  localparam logic [31:0] VPROBE_ARG     = 32'h0000_01AA;
  localparam logic [31:0] HOSTCAP_ARG    = 32'h4000_0000;

  // Payload for each step of the sequence.
  function automatic req_t step_req(step_e s, logic [31:0] wake, logic [31:0] blen);
    req_t r;
    r = '0;
    case (s)
      ST_WAKE:    begin r.dummy = 1'b1; r.arg = wake; end
      ST_RST:     r.idx = 6'd0;
      ST_VCHK:    begin r.idx = 6'd8;  r.arg = VPROBE_ARG; end
      ST_APP1,
      ST_APP2:    r.idx = 6'd55;
      ST_OP1:     r.idx = 6'd41;
      ST_OP2:     begin r.idx = 6'd41; r.arg = HOSTCAP_ARG; end
      ST_OCR,
      ST_OCR_FIN: r.idx = 6'd58;
      ST_BLEN:    begin r.idx = 6'd16; r.arg = blen; end
      default:    r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sdinit_req_port.sv
// Holds one request toward the framer until accepted, and tracks the
// single outstanding reply.
module sdinit_req_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic        ld_dummy,
  input  logic [5:0]  ld_idx,
  input  logic [31:0] ld_arg,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_dummy,
  output logic [5:0]  req_index,
  output logic [31:0] req_arg,
  input  logic        rsp_valid,
  output logic        rsp_take
);

  logic pending_q;
  logic accepted;

  assign accepted = req_valid & req_ready;
  assign rsp_take = rsp_valid & pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_dummy <= 1'b0;
      req_index <= '0;
      req_arg   <= '0;
    end else if (launch) begin
      req_valid <= 1'b1;
      req_dummy <= ld_dummy;
      req_index <= ld_idx;
      req_arg   <= ld_arg;
    end else if (accepted) begin
      req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (accepted) pending_q <= 1'b1;
    else if (rsp_take) pending_q <= 1'b0;
  end

endmodule

// File: rtl/sdinit_retry.sv
// Counts failed initialization attempts; flags the last permitted one.
module sdinit_retry #(
  parameter int unsigned LIMIT = 5000,
  parameter int unsigned W     = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);

  logic [W-1:0] cnt_q;

  assign last = (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (bump) cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/sdinit_gap.sv
// Down-counter for the idle wait between version-2 attempts.
module sdinit_gap #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

endmodule

// File: rtl/sdcard_bringup.sv
module sdcard_bringup
  import sdinit_pkg::*;
#(
  parameter int unsigned WAKE_BYTES  = 16,
  parameter int unsigned RETRY_LIMIT = 5000,
  parameter int unsigned GAP_W       = 16,
  parameter int unsigned BLOCK_LEN   = 512,
  localparam int unsigned UNIT_W     = $clog2(BLOCK_LEN) + 1,
  localparam int unsigned RETRY_W    = $clog2(RETRY_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [GAP_W-1:0]  gap_cycles,
  output logic              busy,
  output logic              done,
  output logic [1:0]        card_type,
  output logic [UNIT_W-1:0] addr_unit,
  output logic              fast_clk_sel,
  output logic [7:0]        status,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_dummy,
  output logic [5:0]        req_index,
  output logic [31:0]       req_arg,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_byte
);

  localparam logic [31:0] WAKE_ARG = 32'(WAKE_BYTES);
  localparam logic [31:0] BLEN_ARG = 32'(BLOCK_LEN);

  phase_e phase_q;
  step_e  step_q;
  card_e  id_q;
  card_e  type_q;
  logic   done_q;
  logic   fast_q;
  logic   up_q;
  logic [UNIT_W-1:0] unit_q;

  logic   rsp_take;
  logic   gap_expired;
  logic   retry_last;

  // Decision taken on each reply
  step_e  d_step;
  logic   d_launch, d_gap, d_ok, d_fail, d_bump, d_clr, d_set_id;
  card_e  d_id;

  always_comb begin
    d_step   = step_q;
    d_launch = 1'b0;
    d_gap    = 1'b0;
    d_ok     = 1'b0;
    d_fail   = 1'b0;
    d_bump   = 1'b0;
    d_clr    = 1'b0;
    d_set_id = 1'b0;
    d_id     = CARD_FAIL;
    case (step_q)
      ST_WAKE: begin
        d_step = ST_RST; d_launch = 1'b1;
      end
      ST_RST: begin
        if (rsp_byte == REPLY_IDLE) begin d_step = ST_VCHK; d_launch = 1'b1; end
        else d_fail = 1'b1;
      end
      ST_VCHK: begin
        if (rsp_byte == REPLY_IDLE) begin
          d_clr = 1'b1; d_set_id = 1'b1; d_id = CARD_V2;
          d_step = ST_OCR; d_gap = 1'b1;
        end else if (rsp_byte == REPLY_IDLE_ILL) begin
          d_clr = 1'b1; d_set_id = 1'b1; d_id = CARD_V1;
          d_step = ST_APP1; d_launch = 1'b1;
        end else begin
          d_fail = 1'b1;
        end
      end
      ST_APP1: begin
        d_step = ST_OP1; d_launch = 1'b1;
      end
      ST_OP1: begin
        if (rsp_byte == REPLY_READY) begin d_step = ST_BLEN; d_launch = 1'b1; end
        else if (retry_last)         d_fail = 1'b1;
        else begin d_bump = 1'b1; d_step = ST_APP1; d_launch = 1'b1; end
      end
      ST_OCR: begin
        d_step = ST_APP2; d_launch = 1'b1;
      end
      ST_APP2: begin
        d_step = ST_OP2; d_launch = 1'b1;
      end
      ST_OP2: begin
        if (rsp_byte == REPLY_READY) begin d_step = ST_OCR_FIN; d_launch = 1'b1; end
        else if (retry_last)         d_fail = 1'b1;
        else begin d_bump = 1'b1; d_step = ST_OCR; d_gap = 1'b1; end
      end
      ST_OCR_FIN: begin
        d_step = ST_BLEN; d_launch = 1'b1;
      end
      ST_BLEN: begin
        if (rsp_byte == REPLY_READY) d_ok = 1'b1;
        else                         d_fail = 1'b1;
      end
      default: d_fail = 1'b1;
    endcase
  end

  // Launch selection
  logic start_go, gap_fire, reply_go, launch;
  req_t lreq;

  assign start_go = (phase_q == P_IDLE) && start;
  assign gap_fire = (phase_q == P_GAP) && gap_expired;
  assign reply_go = (phase_q == P_BUSY) && rsp_take && d_launch;
  assign launch   = start_go | gap_fire | reply_go;

  always_comb begin
    case (phase_q)
      P_IDLE:  lreq = step_req(ST_WAKE, WAKE_ARG, BLEN_ARG);
      P_GAP:   lreq = step_req(step_q, WAKE_ARG, BLEN_ARG);
      default: lreq = step_req(d_step, WAKE_ARG, BLEN_ARG);
    endcase
  end

  logic on_reply;
  assign on_reply = (phase_q == P_BUSY) && rsp_take;

  sdinit_req_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .ld_dummy  (lreq.dummy),
    .ld_idx    (lreq.idx),
    .ld_arg    (lreq.arg),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_dummy (req_dummy),
    .req_index (req_index),
    .req_arg   (req_arg),
    .rsp_valid (rsp_valid),
    .rsp_take  (rsp_take)
  );

  sdinit_retry #(.LIMIT(RETRY_LIMIT), .W(RETRY_W)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (on_reply & d_clr),
    .bump  (on_reply & d_bump),
    .last  (retry_last)
  );

  sdinit_gap #(.W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (on_reply & d_gap),
    .load_val (gap_cycles),
    .expired  (gap_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= P_IDLE;
      step_q  <= ST_WAKE;
      id_q    <= CARD_FAIL;
      type_q  <= CARD_FAIL;
      unit_q  <= '0;
      fast_q  <= 1'b0;
      up_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        P_IDLE: begin
          if (start) begin
            phase_q <= P_BUSY;
            step_q  <= ST_WAKE;
            id_q    <= CARD_FAIL;
            type_q  <= CARD_FAIL;
            unit_q  <= '0;
            fast_q  <= 1'b0;
            up_q    <= 1'b0;
          end
        end
        P_GAP: begin
          if (gap_expired) phase_q <= P_BUSY;
        end
        P_BUSY: begin
          if (rsp_take) begin
            step_q <= d_step;
            if (d_set_id) id_q <= d_id;
            if (d_gap) phase_q <= P_GAP;
            if (d_ok) begin
              phase_q <= P_IDLE;
              done_q  <= 1'b1;
              type_q  <= id_q;
              unit_q  <= (id_q == CARD_V1) ? UNIT_W'(BLOCK_LEN) : UNIT_W'(1);
              fast_q  <= 1'b1;
              up_q    <= 1'b1;
            end
            if (d_fail) begin
              phase_q <= P_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: phase_q <= P_IDLE;
      endcase
    end
  end

  assign busy         = (phase_q != P_IDLE);
  assign done         = done_q;
  assign card_type    = type_q;
  assign addr_unit    = unit_q;
  assign fast_clk_sel = fast_q;
  assign status       = {7'd0, ~up_q};

endmodule

// File: rtl/sdcard_bringup_chk.sv
module sdcard_bringup_chk #(
  parameter int unsigned BLOCK_LEN = 512,
  parameter int unsigned UNIT_W    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        card_type,
  input logic [UNIT_W-1:0] addr_unit,
  input logic              fast_clk_sel,
  input logic [7:0]        status,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_dummy,
  input logic [5:0]        req_index,
  input logic [31:0]       req_arg
);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_index) && $stable(req_arg) && $stable(req_dummy));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_fast_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_clk_sel) |-> done && (status == 8'h00));

  a_r9_ready_status: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h00) |-> (card_type != 2'd0) && fast_clk_sel && !busy);

  a_r9_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done && (card_type == 2'd0) |-> !fast_clk_sel && (status == 8'h01) && (addr_unit == '0));

  a_r4_v1_unit: assert property (@(posedge clk) disable iff (!rst_n)
    done && (card_type == 2'd1) |-> addr_unit == UNIT_W'(BLOCK_LEN));

  a_r5_v2_unit: assert property (@(posedge clk) disable iff (!rst_n)
    done && (card_type == 2'd2) |-> addr_unit == UNIT_W'(1));

endmodule

bind sdcard_bringup sdcard_bringup_chk #(.BLOCK_LEN(BLOCK_LEN), .UNIT_W(UNIT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .card_type    (card_type),
  .addr_unit    (addr_unit),
  .fast_clk_sel (fast_clk_sel),
  .status       (status),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_dummy    (req_dummy),
  .req_index    (req_index),
  .req_arg      (req_arg)
);

// File: tb/sdcard_bringup_tb_top.sv
module sdcard_bringup_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_LIMIT   = 5;
  localparam int WAKE_N     = 16;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] gap_cycles = '0;
  logic        busy, done, fast_clk_sel;
  logic [1:0]  card_type;
  logic [9:0]  addr_unit;
  logic [7:0]  status;
  logic        req_valid, req_dummy;
  logic        req_ready = 1'b0;
  logic [5:0]  req_index;
  logic [31:0] req_arg;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcard_bringup #(.WAKE_BYTES(WAKE_N), .RETRY_LIMIT(TB_LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .gap_cycles(gap_cycles),
    .busy(busy), .done(done), .card_type(card_type), .addr_unit(addr_unit),
    .fast_clk_sel(fast_clk_sel), .status(status),
    .req_valid(req_valid), .req_ready(req_ready), .req_dummy(req_dummy),
    .req_index(req_index), .req_arg(req_arg),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- reference model: expected request stream ----------------
  typedef struct packed {
    logic        d;
    logic [5:0]  i;
    logic [31:0] a;
    logic        g;
  } exp_t;

  exp_t q[$];
  exp_t cur;

  logic [7:0] s_r0, s_r8, s_r16;
  int         s_busy, s_alat, s_rlat, s_poke, s_gap;
  int         busy_left;
  string      s_tag;
  logic [1:0] exp_type;
  logic [9:0] exp_unit;
  logic       exp_ok;

  task automatic push(input logic d, input logic [5:0] i, input logic [31:0] a, input logic g);
    q.push_back('{d: d, i: i, a: a, g: g});
  endtask

  task automatic build();
    bit found;
    q.delete();
    exp_ok = 1'b0; exp_type = 2'd0; exp_unit = 10'd0; found = 1'b0;
    push(1'b1, 6'd0, 32'(WAKE_N), 1'b0);
    push(1'b0, 6'd0, 32'd0, 1'b0);
    if (s_r0 == 8'h01) begin
      push(1'b0, 6'd8, 32'h1AA, 1'b0);
      if (s_r8 == 8'h01) begin
        for (int a = 0; a < TB_LIMIT && !found; a++) begin
          push(1'b0, 6'd58, 32'd0, 1'b1);
          push(1'b0, 6'd55, 32'd0, 1'b0);
          push(1'b0, 6'd41, 32'h4000_0000, 1'b0);
          if (a == s_busy) begin
            push(1'b0, 6'd58, 32'd0, 1'b0);
            found = 1'b1;
          end
        end
        if (found) begin exp_type = 2'd2; exp_unit = 10'd1; end
      end else if (s_r8 == 8'h05) begin
        for (int a = 0; a < TB_LIMIT && !found; a++) begin
          push(1'b0, 6'd55, 32'd0, 1'b0);
          push(1'b0, 6'd41, 32'd0, 1'b0);
          if (a == s_busy) found = 1'b1;
        end
        if (found) begin exp_type = 2'd1; exp_unit = 10'd512; end
      end
      if (found) begin
        push(1'b0, 6'd16, 32'd512, 1'b0);
        if (s_r16 == 8'h00) exp_ok = 1'b1;
      end
    end
    if (!exp_ok) begin exp_type = 2'd0; exp_unit = 10'd0; end
  endtask

  function automatic string tag_of(input exp_t e);
    if (e.d) return "R1";
    case (e.i)
      6'd0:  return "R2";
      6'd8:  return "R3";
      6'd16: return "R8";
      6'd58: return "R5";
      default: return (e.a == 32'h4000_0000) ? "R5" : "R4";
    endcase
  endfunction

  // ---------------- clock-by-clock monitor and framer model ----------------
  int   cyc = 0;
  always @(posedge clk) cyc++;

  bit   kick = 1'b0;
  bit   running = 1'b0;
  int   run_cyc = 0;
  int   done_cyc = -1;
  int   fst = 0;
  int   fcnt = 0;
  int   last_rsp = 0;
  bit   popped = 1'b0;
  logic        cap_d;
  logic [5:0]  cap_i;
  logic [31:0] cap_a;
  logic [7:0]  reply;

  always @(negedge clk) begin
    if (start) begin
      start = 1'b0;
      if (!running) begin running = 1'b1; run_cyc = cyc; end
    end

    if (running) begin
      if (cyc == done_cyc) begin
        chk(done == 1'b1, "R9 done", done, 1);
        chk(busy == 1'b0, "R9 busy", busy, 0);
        chk(card_type == exp_type, s_tag, card_type, exp_type);
        chk(addr_unit == exp_unit, s_tag, addr_unit, exp_unit);
        chk(fast_clk_sel == exp_ok, "R9 fast", fast_clk_sel, exp_ok);
        chk(status == (exp_ok ? 8'h00 : 8'h01), "R9 status", status, exp_ok ? 0 : 1);
        running = 1'b0;
        done_cyc = -1;
      end else begin
        chk(done == 1'b0, "R9 early done", done, 0);
        chk(busy == 1'b1, "R1 busy", busy, 1);
        chk(status == 8'h01 && fast_clk_sel == 1'b0, "R9 in-run", {status, 7'd0, fast_clk_sel}, 16'h0100);
      end
      if (s_poke > 0 && cyc == run_cyc + s_poke) start = 1'b1;
    end

    rsp_valid = 1'b0;
    case (fst)
      0: if (req_valid) begin
        cap_d = req_dummy; cap_i = req_index; cap_a = req_arg;
        if (q.size() == 0) begin
          popped = 1'b0;
          chk(1'b0, "R6 unexpected request", {req_dummy, req_index, req_arg}, 0);
        end else begin
          cur = q.pop_front();
          popped = 1'b1;
          chk(req_dummy == cur.d && req_index == cur.i && req_arg == cur.a, tag_of(cur),
              {req_dummy, req_index, req_arg}, {cur.d, cur.i, cur.a});
          if (!cur.d) begin
            if (cur.g) chk(cyc - last_rsp == s_gap + 2, "R7 gap", cyc - last_rsp, s_gap + 2);
            else       chk(cyc - last_rsp == 1, "R10 issue", cyc - last_rsp, 1);
          end
        end
        if (s_alat == 0) begin req_ready = 1'b1; fst = 2; end
        else begin fcnt = s_alat; fst = 1; end
      end
      1: begin
        chk(req_valid && req_dummy == cap_d && req_index == cap_i && req_arg == cap_a,
            "R10 hold", {req_valid, req_dummy, req_index, req_arg}, {1'b1, cap_d, cap_i, cap_a});
        fcnt--;
        if (fcnt == 0) begin req_ready = 1'b1; fst = 2; end
      end
      2: begin
        req_ready = 1'b0;
        if (cap_d) reply = 8'hFF;
        else case (cap_i)
          6'd0:  reply = s_r0;
          6'd8:  reply = s_r8;
          6'd16: reply = s_r16;
          6'd41: if (busy_left > 0) begin busy_left--; reply = 8'h01; end else reply = 8'h00;
          default: reply = 8'h01;
        endcase
        fcnt = s_rlat;
        fst = 3;
      end
      default: begin
        fcnt--;
        if (fcnt <= 0) begin
          rsp_valid = 1'b1;
          rsp_byte = reply;
          last_rsp = cyc;
          if (popped && q.size() == 0) done_cyc = cyc + 1;
          fst = 0;
        end
      end
    endcase

    if (kick) begin kick = 1'b0; start = 1'b1; end

    if (cyc > WD_CYCLES) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WD_CYCLES);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [7:0] r0, input logic [7:0] r8, input logic [7:0] r16,
                     input int busyn, input int gap, input int alat, input int rlat,
                     input int poke, input string tag);
    s_r0 = r0; s_r8 = r8; s_r16 = r16; s_busy = busyn; s_gap = gap;
    s_alat = alat; s_rlat = rlat; s_poke = poke; s_tag = tag;
    gap_cycles = 16'(gap);
    busy_left = busyn;
    build();
    kick = 1'b1;
    wait (running == 1'b1);
    wait (running == 1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R9, R10)
    chk(busy == 0 && done == 0, "R9 reset busy/done", {busy, done}, 0);
    chk(status == 8'h01 && fast_clk_sel == 0, "R9 reset status", {status, fast_clk_sel}, 9'h002);
    chk(card_type == 0 && addr_unit == 0, "R9 reset type", {card_type, addr_unit}, 0);
    chk(req_valid == 0, "R10 reset request", req_valid, 0);

    run(8'h01, 8'h01, 8'h00, 2, 3, 0, 1, 0, "R5 v2 success");
    run(8'h01, 8'h05, 8'h00, 1, 0, 2, 3, 0, "R4 v1 success");
    run(8'h00, 8'h01, 8'h00, 0, 0, 1, 1, 0, "R2 bad reset reply");
    run(8'h01, 8'h09, 8'h00, 0, 0, 0, 2, 0, "R3 bad probe reply");
    run(8'h01, 8'h05, 8'h00, 9, 0, 1, 1, 0, "R6 v1 timeout");
    run(8'h01, 8'h01, 8'h00, 9, 1, 0, 1, 0, "R6 v2 timeout");
    run(8'h01, 8'h01, 8'h04, 0, 0, 3, 2, 0, "R8 block length rejected");
    run(8'h01, 8'h05, 8'h00, 0, 0, 1, 1, 5, "R1 start while busy");
    run(8'h01, 8'h01, 8'h00, TB_LIMIT - 1, 2, 1, 2, 0, "R6 v2 last attempt");
    run(8'h01, 8'h05, 8'h00, TB_LIMIT - 1, 0, 0, 1, 0, "R6 v1 last attempt");
    run(8'h01, 8'h01, 8'h00, 0, 0, 0, 1, 9, "R5 v2 first attempt");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule